// File: doc/BRIEF.md
# Streaming Hit Finder

This block watches a time-multiplexed stream of filtered, baseline-corrected signed samples covering many detector channels and extracts hits from it. A hit on a channel is an unbroken run of that channel's samples that lie strictly above a shared programmable threshold. Each channel keeps its own partial-hit state, so samples of different channels may be interleaved in any order. When a channel's run ends, the block produces one compact record with the channel number, the timestamp of the run's first sample, the number of samples in the run, the largest sample seen and the saturating signed sum of the samples.

Timestamps come from an internal sample-tick counter. It starts at zero and advances after each accepted sample for the highest-numbered channel, so all samples of one pass over the channels share one tick value. Records leave through a single-entry valid/ready output register. A record that arrives while that register is still held by a stalled consumer is discarded, and a counter of lost records is incremented.

Top module: `hit_finder`

## Requirements
- R1: After reset out_valid is 0, overflow_count is 0 and no channel is inside a hit, so a below-threshold sample produces no record.
- R2: A hit opens only on a sample strictly greater than threshold under a signed comparison. A sample equal to threshold does not open a hit.
- R3: An open hit closes on the first sample at or below threshold. On the clock edge that accepts that sample, out_valid rises with the record, and the closing sample is not part of the record.
- R4: out_start is the tick value of the hit's first sample. The tick is 0 after reset and increments by one after each accepted sample whose channel is N_CH-1.
- R5: out_len is the number of above-threshold samples in the hit, and out_peak is the largest of them.
- R6: out_sum is the signed sum of the hit's samples. Each addition clamps to the SUM_W-bit signed range, so the sum stops at the maximum or the minimum value.
- R7: When a hit reaches MAX_LEN samples it is closed by force. A record with out_len = MAX_LEN is emitted on the edge that accepts that sample, and the next above-threshold sample on that channel opens a new hit. out_len is never 0 and never exceeds MAX_LEN.
- R8: Channels are independent. out_chan names the channel of the record, and a sample for one channel never alters the hit state of another.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and every record field holds its value.
- R10: If a new record is produced while out_valid is 1 and out_ready is 0, the new record is discarded, the held record is kept, and overflow_count increments by one.
- R11: A cycle with in_valid low changes no hit state and the tick, and produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_chan | input | CH_W | Channel of the sample |
| in_sample | input | SAMPLE_W | Signed sample value |
| threshold | input | SAMPLE_W | Signed hit threshold |
| out_valid | output | 1 | Record register holds a record |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_chan | output | CH_W | Channel of the record |
| out_start | output | TS_W | Tick of the first hit sample |
| out_len | output | LEN_W | Number of samples in the hit |
| out_peak | output | SAMPLE_W | Largest hit sample (signed) |
| out_sum | output | SUM_W | Saturated signed sum of hit samples |
| overflow_count | output | OVF_W | Records lost to a stalled output |

## Verification
The bench goes after samples exactly equal to the threshold. A design with an off-by-one comparison would open hits on them or fail to close hits on them, and the peak or the length would then be wrong. It drives long runs of full-scale samples of both signs to check the clamping: a sum that wraps flips sign. A run longer than MAX_LEN shows whether the forced close happens at the right sample and whether a new hit opens straight after it, since a design with an off-by-one count would report 254 or 256. Two records produced behind a stalled consumer show whether the held record gets overwritten and whether the overflow count is missing.

// File: rtl/hit_finder_pkg.sv
package hit_finder_pkg;

    // What one accepted sample does to its channel's hit state
    typedef enum logic [2:0] {
        ACT_NONE,   // idle and below threshold
        ACT_OPEN,   // first sample above threshold
        ACT_GROW,   // further sample above threshold
        ACT_CLOSE,  // sample at or below threshold ends the hit
        ACT_FORCE   // hit reached its length limit
    } hf_act_e;

endpackage

// File: rtl/hf_tick.sv
module hf_tick #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    output logic [TS_W-1:0] tick_o
);
    typedef struct packed {
        logic [TS_W-1:0] tick;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) st_d.tick = st_q.tick + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R4: the tick moves only after a sample for the last channel
    assert_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q.tick));
endmodule

// File: rtl/hf_state_mem.sv
module hf_state_mem #(
    parameter int N_CH    = 64,
    parameter int ENTRY_W = 70,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CH_W-1:0]    rd_addr_i,
    output logic [ENTRY_W-1:0] rd_data_o,
    input  logic               wr_en_i,
    input  logic [CH_W-1:0]    wr_addr_i,
    input  logic [ENTRY_W-1:0] wr_data_i
);
    logic [ENTRY_W-1:0] mem_d [N_CH];
    logic [ENTRY_W-1:0] mem_q [N_CH];

    always_comb begin
        for (int i = 0; i < N_CH; i++) mem_d[i] = mem_q[i];
        if (wr_en_i) mem_d[wr_addr_i] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/hf_update.sv
module hf_update
    import hit_finder_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TS_W     = 32,
    parameter int LEN_W    = 8,
    parameter int SUM_W    = 20,
    parameter int MAX_LEN  = 255,
    localparam int ENTRY_W = 1 + TS_W + LEN_W + SAMPLE_W + SUM_W
) (
    input  logic [ENTRY_W-1:0]         cur_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [SAMPLE_W-1:0] threshold_i,
    input  logic [TS_W-1:0]            tick_i,
    output logic [ENTRY_W-1:0]         nxt_o,
    output logic                       emit_o,
    output logic [TS_W-1:0]            rec_start_o,
    output logic [LEN_W-1:0]           rec_len_o,
    output logic signed [SAMPLE_W-1:0] rec_peak_o,
    output logic signed [SUM_W-1:0]    rec_sum_o
);
    typedef struct packed {
        logic                       open;
        logic [TS_W-1:0]            start;
        logic [LEN_W-1:0]           len;
        logic signed [SAMPLE_W-1:0] peak;
        logic signed [SUM_W-1:0]    sum;
    } entry_t;

    entry_t              cur, grown, nxt;
    hf_act_e             act;
    logic                above;
    logic [SUM_W-1:0]    base;
    logic [SUM_W:0]      wide;

    always_comb begin
        cur   = entry_t'(cur_i);
        above = sample_i > threshold_i;

        // state after absorbing this sample into a (new or open) hit
        grown.open  = 1'b1;
        grown.start = cur.open ? cur.start : tick_i;
        if (!cur.open)           grown.len = LEN_W'(1);
        else if (&cur.len)       grown.len = cur.len;
        else                     grown.len = cur.len + LEN_W'(1);
        grown.peak  = (cur.open && cur.peak >= sample_i) ? cur.peak : sample_i;
        base        = cur.open ? cur.sum : '0;
        wide        = {base[SUM_W-1], base}
                    + {{(SUM_W + 1 - SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
        if (wide[SUM_W] != wide[SUM_W-1])
            grown.sum = wide[SUM_W] ? {1'b1, {(SUM_W-1){1'b0}}}
                                    : {1'b0, {(SUM_W-1){1'b1}}};
        else
            grown.sum = wide[SUM_W-1:0];

        if (above) begin
            if (grown.len == LEN_W'(MAX_LEN)) act = ACT_FORCE;
            else if (cur.open)                act = ACT_GROW;
            else                              act = ACT_OPEN;
        end else begin
            act = cur.open ? ACT_CLOSE : ACT_NONE;
        end

        nxt    = cur;
        emit_o = 1'b0;
        case (act)
            ACT_OPEN, ACT_GROW: nxt = grown;
            ACT_FORCE: begin
                nxt      = grown;
                nxt.open = 1'b0;
                emit_o   = 1'b1;
            end
            ACT_CLOSE: begin
                nxt.open = 1'b0;
                emit_o   = 1'b1;
            end
            default: nxt = cur;
        endcase

        rec_start_o = (act == ACT_CLOSE) ? cur.start : grown.start;
        rec_len_o   = (act == ACT_CLOSE) ? cur.len   : grown.len;
        rec_peak_o  = (act == ACT_CLOSE) ? cur.peak  : grown.peak;
        rec_sum_o   = (act == ACT_CLOSE) ? cur.sum   : grown.sum;
    end

    assign nxt_o = nxt;
endmodule

// File: rtl/hf_out_stage.sv
module hf_out_stage #(
    parameter int REC_W = 64,
    parameter int OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_i,
    input  logic [REC_W-1:0] new_rec_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [REC_W-1:0] rec_o,
    output logic [OVF_W-1:0] ovf_o
);
    typedef struct packed {
        logic             valid;
        logic [REC_W-1:0] rec;
        logic [OVF_W-1:0] ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (new_i) begin
            if (st_q.valid && !ready_i) begin
                st_d.ovf = st_q.ovf + OVF_W'(1);
            end else begin
                st_d.valid = 1'b1;
                st_d.rec   = new_rec_i;
            end
        end else if (st_q.valid && ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign rec_o   = st_q.rec;
    assign ovf_o   = st_q.ovf;

    // R9: a stalled record stays put
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !ready_i) |=> (st_q.valid && $stable(st_q.rec)));

    // R10: lost records counted one at a time
    assert_ovf_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.ovf == $past(st_q.ovf)) || (st_q.ovf == $past(st_q.ovf) + OVF_W'(1)));
endmodule

// File: rtl/hit_finder.sv
module hit_finder #(
    parameter int N_CH     = 64,
    parameter int SAMPLE_W = 12,
    parameter int TS_W     = 32,
    parameter int LEN_W    = 8,
    parameter int SUM_W    = 20,
    parameter int MAX_LEN  = 255,
    parameter int OVF_W    = 16,
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_chan,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic signed [SAMPLE_W-1:0] threshold,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [CH_W-1:0]            out_chan,
    output logic [TS_W-1:0]            out_start,
    output logic [LEN_W-1:0]           out_len,
    output logic signed [SAMPLE_W-1:0] out_peak,
    output logic signed [SUM_W-1:0]    out_sum,
    output logic [OVF_W-1:0]           overflow_count
);
    localparam int ENTRY_W = 1 + TS_W + LEN_W + SAMPLE_W + SUM_W;
    localparam int REC_W   = CH_W + TS_W + LEN_W + SAMPLE_W + SUM_W;

    logic [TS_W-1:0]            tick;
    logic [ENTRY_W-1:0]         cur_entry, nxt_entry;
    logic                       emit;
    logic [TS_W-1:0]            rec_start;
    logic [LEN_W-1:0]           rec_len;
    logic signed [SAMPLE_W-1:0] rec_peak;
    logic signed [SUM_W-1:0]    rec_sum;
    logic [REC_W-1:0]           rec_out;

    hf_tick #(.TS_W(TS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (in_valid && (in_chan == CH_W'(N_CH - 1))),
        .tick_o (tick)
    );

    hf_state_mem #(.N_CH(N_CH), .ENTRY_W(ENTRY_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (in_chan),
        .rd_data_o (cur_entry),
        .wr_en_i   (in_valid),
        .wr_addr_i (in_chan),
        .wr_data_i (nxt_entry)
    );

    hf_update #(
        .SAMPLE_W (SAMPLE_W),
        .TS_W     (TS_W),
        .LEN_W    (LEN_W),
        .SUM_W    (SUM_W),
        .MAX_LEN  (MAX_LEN)
    ) u_upd (
        .cur_i       (cur_entry),
        .sample_i    (in_sample),
        .threshold_i (threshold),
        .tick_i      (tick),
        .nxt_o       (nxt_entry),
        .emit_o      (emit),
        .rec_start_o (rec_start),
        .rec_len_o   (rec_len),
        .rec_peak_o  (rec_peak),
        .rec_sum_o   (rec_sum)
    );

    hf_out_stage #(.REC_W(REC_W), .OVF_W(OVF_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_i     (in_valid && emit),
        .new_rec_i ({in_chan, rec_start, rec_len, rec_peak, rec_sum}),
        .ready_i   (out_ready),
        .valid_o   (out_valid),
        .rec_o     (rec_out),
        .ovf_o     (overflow_count)
    );

    assign {out_chan, out_start, out_len, out_peak, out_sum} = rec_out;

    // R11: with no sample and nothing stalled, no record can appear
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !(out_valid && !out_ready)) |=> !out_valid);

    // R7: record length stays within 1..MAX_LEN
    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0) && (out_len <= LEN_W'(MAX_LEN)));
endmodule

// File: tb/hit_finder_test.sv
module hit_finder_test;
    localparam int NC   = 4;
    localparam int SW   = 12;
    localparam int TW   = 32;
    localparam int LW   = 8;
    localparam int UW   = 16;
    localparam int MAXL = 255;
    localparam int OW   = 16;
    localparam int CW   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [CW-1:0]        in_chan = '0;
    logic signed [SW-1:0] in_sample = '0;
    logic signed [SW-1:0] threshold = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b1;
    logic [CW-1:0]        out_chan;
    logic [TW-1:0]        out_start;
    logic [LW-1:0]        out_len;
    logic signed [SW-1:0] out_peak;
    logic signed [UW-1:0] out_sum;
    logic [OW-1:0]        overflow_count;

    always #10 clk = ~clk;

    hit_finder #(.N_CH(NC), .SAMPLE_W(SW), .TS_W(TW), .LEN_W(LW),
                 .SUM_W(UW), .MAX_LEN(MAXL), .OVF_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .threshold(threshold), .out_valid(out_valid),
        .out_ready(out_ready), .out_chan(out_chan), .out_start(out_start),
        .out_len(out_len), .out_peak(out_peak), .out_sum(out_sum),
        .overflow_count(overflow_count));

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int m_open[NC], m_start[NC], m_len[NC], m_peak[NC], m_sum[NC];
    int m_tick = 0, thr = 0;
    int e_valid = 0, e_chan = 0, e_start = 0, e_len = 0, e_peak = 0, e_sum = 0, e_ovf = 0;

    function automatic int clampsum(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(bit v, int ch, int s, bit rdy, string tag);
        bit nr; int rc, rs, rl, rp, ru;
        in_valid = v; in_chan = CW'(ch); in_sample = SW'(s); out_ready = rdy;
        @(posedge clk);
        nr = 0; rc = ch; rs = 0; rl = 0; rp = 0; ru = 0;
        if (v) begin
            if (s > thr) begin
                if (!m_open[ch]) begin
                    m_open[ch] = 1; m_start[ch] = m_tick; m_len[ch] = 1;
                    m_peak[ch] = s; m_sum[ch] = clampsum(s);
                end else begin
                    m_len[ch]++;
                    if (s > m_peak[ch]) m_peak[ch] = s;
                    m_sum[ch] = clampsum(m_sum[ch] + s);
                end
                if (m_len[ch] == MAXL) begin
                    nr = 1; rs = m_start[ch]; rl = m_len[ch]; rp = m_peak[ch]; ru = m_sum[ch];
                    m_open[ch] = 0;
                end
            end else if (m_open[ch]) begin
                nr = 1; rs = m_start[ch]; rl = m_len[ch]; rp = m_peak[ch]; ru = m_sum[ch];
                m_open[ch] = 0;
            end
            if (ch == NC - 1) m_tick++;
        end
        if (nr) begin
            if (e_valid && !rdy) e_ovf++;
            else begin
                e_valid = 1; e_chan = rc; e_start = rs; e_len = rl; e_peak = rp; e_sum = ru;
            end
        end else if (e_valid && rdy) e_valid = 0;
        @(negedge clk);
        check(tag, int'(out_valid), e_valid);
        if (e_valid) begin
            check("R8 chan", int'(out_chan), e_chan);
            check("R4 start", int'(out_start), e_start);
            check("R5 len", int'(out_len), e_len);
            check("R5 peak", int'($signed(out_peak)), e_peak);
            check("R6 sum", int'($signed(out_sum)), e_sum);
        end
        check("R10 overflow", int'(overflow_count), e_ovf);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_open[c] = 0; m_start[c] = 0; m_len[c] = 0; m_peak[c] = 0; m_sum[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 overflow", int'(overflow_count), 0);
        thr = 100; threshold = SW'(thr);
        for (int c = 0; c < NC; c++) step(1, c, 50, 1, "R1");

        // R3 R8: interleaved sweep with varied run lengths and amplitudes
        for (int p = 0; p < 80; p++) begin
            for (int c = 0; c < NC; c++) begin
                int seg, val, s;
                seg = (p + 5 * c) % (c + 6);
                val = (p * 7 + c * 13) % 60;
                if (seg < c + 2)       s = 101 + val * 30;
                else if (seg == c + 2) s = 100;
                else                   s = -(val * 20);
                if (p % 9 == 4 && c == 2) step(0, 3, 900, 1, "R11");
                step(1, c, s, 1, "R3");
            end
        end

        // R2: equal to threshold neither opens nor extends a hit
        step(1, 0, 100, 1, "R2");
        step(1, 0, 101, 1, "R2");
        step(1, 0, 100, 1, "R2");
        step(1, 1, 100, 1, "R2");
        step(1, 2, 100, 1, "R2");
        step(1, 3, 100, 1, "R2");

        // R6: positive and negative saturation
        thr = -2000; threshold = SW'(thr);
        for (int p = 0; p < 22; p++) begin
            step(1, 0, 2047, 1, "R6");
            step(1, 1, -1500, 1, "R6");
            step(1, 2, -2000, 1, "R6");
            step(1, 3, -2047, 1, "R6");
        end
        step(1, 0, -2000, 1, "R6");
        step(1, 1, -2000, 1, "R6");

        // R7: forced close at MAX_LEN, then a fresh hit
        thr = 0; threshold = '0;
        for (int p = 0; p < 300; p++) begin
            for (int c = 0; c < NC; c++) step(1, c, (c == 2) ? 10 + (p % 5) : 0, 1, "R7");
        end
        step(1, 2, 0, 1, "R7");

        // R9 R10: stalled consumer, second record dropped
        step(1, 0, 5, 0, "R9");
        step(1, 0, 0, 0, "R9");
        step(1, 1, 7, 0, "R9");
        step(1, 1, 0, 0, "R10");
        step(0, 0, 0, 0, "R9");
        step(0, 0, 0, 1, "R9");
        step(0, 0, 0, 1, "R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule